// File: doc/BRIEF.md
# Memory Request Classifier and Issuer

This block sits between a processor's load/store port and a cache controller. Each cycle it may receive one memory packet, described by a set of attribute bits: read, write, flush, instruction fetch, linked/conditional access, locked read-modify-write and a store-check hint. It decodes these bits into two 4-bit request types. The primary type goes to an external outstanding-request tracker, which uses it to decide table placement and aliasing. The secondary type is the coherence request that is later sent to the controller.

The tracker answers in the same cycle with a status of ready, aliased or full. The block reports the outcome to the requester one cycle later. Only a ready answer lets the request enter a short in-order delay pipeline. Each pipeline entry counts down a hit latency, and when it reaches the head with its count expired it is presented to the controller for one cycle. The latency is the instruction-side value for a fetch and the data-side value for everything else. Both values are programmable and can never be zero. A packet that matches no legal combination is never shown to the tracker and raises a one-cycle error pulse.

Top module: `mreq_issuer`

## Requirements
- R1: After reset, `trk_req_valid`, `rsp_valid`, `err_pulse` and `ctl_valid` are low, the pipeline is empty, the instruction-side latency is 2 and the data-side latency is 3.
- R2: Type codes are LOAD=0, STORE=1, IFETCH=2, RMW_READ=3, LOCKED_RMW_READ=4, LOCKED_RMW_WRITE=5, LOAD_LINKED=6, STORE_COND=7, ATOMIC=8, FLUSH=9. A linked/conditional packet has the highest decode priority. With write set it gives primary STORE_COND (7), otherwise with read set it gives primary LOAD_LINKED (6). Its secondary type is ATOMIC (8) in both cases.
- R3: Without the linked bit, a locked packet with write set gives primary LOCKED_RMW_WRITE (5). With only read set it gives primary LOCKED_RMW_READ (4). Its secondary type is STORE (1).
- R4: A plain read gives IFETCH/IFETCH (2/2) when the fetch bit is set. With the store-check bit set (and no fetch bit) it gives RMW_READ/STORE (3/1). Otherwise it gives LOAD/LOAD (0/0).
- R5: A plain packet without read and with write gives STORE/STORE. With only flush set it gives FLUSH/FLUSH. Read takes priority over write and flush.
- R6: A packet with none of read, write or flush set, and a linked or locked packet with neither read nor write set, is illegal. No tracker request is made. One cycle later `rsp_code` is 3 and `err_pulse` is high for exactly that cycle.
- R7: `trk_status` encoding is 0=ready, 1=aliased, 2 or 3=full. Only ready puts the request in the pipeline. Aliased returns code 1 and full returns code 2, and nothing reaches the controller.
- R8: A request accepted at clock edge T is presented on `ctl_*` in the cycle after edge T+L (when not blocked by an earlier entry). L is the instruction latency when the secondary type is IFETCH, and the data latency otherwise.
- R9: Requests leave the pipeline in acceptance order. An entry whose count has expired waits behind an older one.
- R10: A `cfg_we` write with `cfg_sel`=1 sets the instruction latency and with `cfg_sel`=0 sets the data latency. A zero value is ignored. A new value applies to requests accepted at later edges.
- R11: When the pipeline holds DEPTH entries, a legal packet gets no tracker request and returns code 2 (full).
- R12: `rsp_valid` is high exactly one cycle after each packet, with code 0 for an issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_rd | input | 1 | Packet reads |
| pkt_wr | input | 1 | Packet writes |
| pkt_flush | input | 1 | Packet is a flush |
| pkt_ifetch | input | 1 | Read is an instruction fetch |
| pkt_llsc | input | 1 | Linked load / conditional store |
| pkt_locked | input | 1 | Locked read-modify-write half |
| pkt_stchk | input | 1 | Store-check hint on a data read |
| pkt_addr | input | AW | Packet address |
| trk_req_valid | output | 1 | Request offered to tracker |
| trk_type | output | 4 | Primary type |
| trk_addr | output | AW | Address to tracker |
| trk_status | input | 2 | Tracker answer, same cycle |
| rsp_valid | output | 1 | Outcome valid |
| rsp_code | output | 2 | 0 issued, 1 aliased, 2 full, 3 illegal |
| err_pulse | output | 1 | Illegal packet pulse |
| ctl_valid | output | 1 | Request to controller |
| ctl_type | output | 4 | Secondary type |
| ctl_addr | output | AW | Address to controller |
| cfg_we | input | 1 | Latency write strobe |
| cfg_sel | input | 1 | 1 instruction, 0 data latency |
| cfg_lat | input | LW | Latency value |

## Verification
The tracker-facing outputs are combinational and are checked in the same cycle the packet is driven. The outcome and error pulse are due one edge later and are checked in the next cycle against the expectation saved from the packet's cycle. Controller output is due L edges after acceptance, or later when an older entry blocks it. The reference model keeps a queue of remaining counts, decrements them once per edge and compares the head on every cycle. That comparison covers the latency choice, in-order blocking, reprogramming and full-pipeline refusal.

// File: rtl/mreq_pkg.sv
package mreq_pkg;

    typedef enum logic [3:0] {
        RT_LOAD      = 4'd0,
        RT_STORE     = 4'd1,
        RT_IFETCH    = 4'd2,
        RT_RMW_RD    = 4'd3,
        RT_LRMW_RD   = 4'd4,
        RT_LRMW_WR   = 4'd5,
        RT_LL        = 4'd6,
        RT_SC        = 4'd7,
        RT_ATOMIC    = 4'd8,
        RT_FLUSH     = 4'd9
    } rtype_e;

    typedef enum logic [1:0] {
        RS_ISSUED  = 2'd0,
        RS_ALIASED = 2'd1,
        RS_FULL    = 2'd2,
        RS_ILLEGAL = 2'd3
    } rsp_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic flush;
        logic ifetch;
        logic llsc;
        logic locked;
        logic stchk;
    } pkt_attr_t;

    typedef struct packed {
        logic   legal;
        rtype_e prim;
        rtype_e sec;
    } class_t;

    // Outcome of a legal packet given pipeline room and tracker answer.
    function automatic rsp_e outcome(input logic room, input logic [1:0] ts);
        if (!room)            return RS_FULL;
        else if (ts == 2'd0)  return RS_ISSUED;
        else if (ts == 2'd1)  return RS_ALIASED;
        else                  return RS_FULL;
    endfunction

endpackage

// File: rtl/mreq_classify.sv
module mreq_classify
    import mreq_pkg::*;
(
    input  pkt_attr_t attr,
    output class_t    cls
);
    always_comb begin
        cls.legal = 1'b1;
        cls.prim  = RT_LOAD;
        cls.sec   = RT_LOAD;
        if (attr.llsc) begin
            cls.sec = RT_ATOMIC;
            if (attr.wr)      cls.prim = RT_SC;
            else if (attr.rd) cls.prim = RT_LL;
            else              cls.legal = 1'b0;
        end else if (attr.locked) begin
            cls.sec = RT_STORE;
            if (attr.wr)      cls.prim = RT_LRMW_WR;
            else if (attr.rd) cls.prim = RT_LRMW_RD;
            else              cls.legal = 1'b0;
        end else if (attr.rd) begin
            if (attr.ifetch) begin
                cls.prim = RT_IFETCH;
                cls.sec  = RT_IFETCH;
            end else if (attr.stchk) begin
                cls.prim = RT_RMW_RD;
                cls.sec  = RT_STORE;
            end
        end else if (attr.wr) begin
            cls.prim = RT_STORE;
            cls.sec  = RT_STORE;
        end else if (attr.flush) begin
            cls.prim = RT_FLUSH;
            cls.sec  = RT_FLUSH;
        end else begin
            cls.legal = 1'b0;
        end
    end
endmodule

// File: rtl/mreq_lat_regs.sv
module mreq_lat_regs #(
    parameter int LW        = 4,
    parameter int I_LAT_RST = 2,
    parameter int D_LAT_RST = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          sel,
    input  logic [LW-1:0] val,
    output logic [LW-1:0] ilat,
    output logic [LW-1:0] dlat
);
    logic nz;
    assign nz = (val != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ilat <= LW'(I_LAT_RST);
            dlat <= LW'(D_LAT_RST);
        end else if (we && nz) begin
            if (sel) ilat <= val;
            else     dlat <= val;
        end
    end
endmodule

// File: rtl/mreq_delay_pipe.sv
module mreq_delay_pipe
    import mreq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rtype_e        push_type,
    input  logic [AW-1:0] push_addr,
    input  logic [LW-1:0] push_lat,
    output logic          full,
    output logic          out_valid,
    output rtype_e        out_type,
    output logic [AW-1:0] out_addr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);

    rtype_e        typ_q  [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [LW-1:0] cnt_q  [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [OW-1:0] occ_q;
    logic          pop;

    assign full      = (occ_q == OW'(DEPTH));
    assign pop       = (occ_q != '0) && (cnt_q[rd_q] == '0);
    assign out_valid = pop;
    assign out_type  = typ_q[rd_q];
    assign out_addr  = addr_q[rd_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g]  <= '0;
                typ_q[g]  <= RT_LOAD;
                addr_q[g] <= '0;
            end else if (push && (wr_q == PW'(g))) begin
                cnt_q[g]  <= push_lat;
                typ_q[g]  <= push_type;
                addr_q[g] <= push_addr;
            end else if (cnt_q[g] != '0) begin
                cnt_q[g]  <= cnt_q[g] - LW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
            case ({push, pop})
                2'b10:   occ_q <= occ_q + OW'(1);
                2'b01:   occ_q <= occ_q - OW'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/mreq_issuer.sv
module mreq_issuer
    import mreq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DEPTH     = 4,
    parameter int LW        = 4,
    parameter int I_LAT_RST = 2,
    parameter int D_LAT_RST = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pkt_valid,
    input  logic          pkt_rd,
    input  logic          pkt_wr,
    input  logic          pkt_flush,
    input  logic          pkt_ifetch,
    input  logic          pkt_llsc,
    input  logic          pkt_locked,
    input  logic          pkt_stchk,
    input  logic [AW-1:0] pkt_addr,
    output logic          trk_req_valid,
    output logic [3:0]    trk_type,
    output logic [AW-1:0] trk_addr,
    input  logic [1:0]    trk_status,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic          err_pulse,
    output logic          ctl_valid,
    output logic [3:0]    ctl_type,
    output logic [AW-1:0] ctl_addr,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [LW-1:0] cfg_lat
);
    pkt_attr_t     attr;
    class_t        cls;
    logic [LW-1:0] ilat_w, dlat_w, push_lat;
    logic          pipe_full, accept;
    rtype_e        ctl_type_e;
    rsp_e          code_d;

    assign attr = '{rd: pkt_rd, wr: pkt_wr, flush: pkt_flush, ifetch: pkt_ifetch,
                    llsc: pkt_llsc, locked: pkt_locked, stchk: pkt_stchk};

    mreq_classify u_cls (.attr(attr), .cls(cls));

    mreq_lat_regs #(.LW(LW), .I_LAT_RST(I_LAT_RST), .D_LAT_RST(D_LAT_RST)) u_lat (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .val(cfg_lat),
        .ilat(ilat_w), .dlat(dlat_w)
    );

    assign trk_req_valid = pkt_valid && cls.legal && !pipe_full;
    assign trk_type      = cls.prim;
    assign trk_addr      = pkt_addr;
    assign accept        = trk_req_valid && (trk_status == 2'd0);
    assign push_lat      = (cls.sec == RT_IFETCH) ? ilat_w : dlat_w;

    mreq_delay_pipe #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_pipe (
        .clk(clk), .rst(rst), .push(accept), .push_type(cls.sec),
        .push_addr(pkt_addr), .push_lat(push_lat), .full(pipe_full),
        .out_valid(ctl_valid), .out_type(ctl_type_e), .out_addr(ctl_addr)
    );
    assign ctl_type = ctl_type_e;

    assign code_d = cls.legal ? outcome(!pipe_full, trk_status) : RS_ILLEGAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RS_ISSUED;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= pkt_valid;
            rsp_code  <= code_d;
            err_pulse <= pkt_valid && !cls.legal;
        end
    end
endmodule

// File: rtl/mreq_issuer_chk.sv
module mreq_issuer_chk #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          pkt_valid,
    input logic          trk_req_valid,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code,
    input logic          err_pulse,
    input logic          ctl_valid,
    input logic [3:0]    ctl_type,
    input logic          cfg_we,
    input logic [LW-1:0] cfg_lat,
    input logic [LW-1:0] ilat,
    input logic [LW-1:0] dlat
);
    a_r12_rsp_after_pkt: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(pkt_valid));

    a_r6_err_has_code: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (rsp_valid && rsp_code == 2'd3));

    a_r7_req_answered: assert property (@(posedge clk) disable iff (rst)
        trk_req_valid |=> (rsp_valid && rsp_code != 2'd3));

    a_r10_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_lat == '0) |=> ($stable(ilat) && $stable(dlat)));

    a_r10_lat_nonzero: assert property (@(posedge clk) disable iff (rst)
        (ilat != '0) && (dlat != '0));

    a_r8_ctl_is_secondary: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> (ctl_type inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd9}));
endmodule

bind mreq_issuer mreq_issuer_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .trk_req_valid(trk_req_valid),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .err_pulse(err_pulse),
    .ctl_valid(ctl_valid), .ctl_type(ctl_type), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
    .ilat(ilat_w), .dlat(dlat_w)
);

// File: tb/mreq_issuer_tb.sv
`timescale 1ns/1ps
module mreq_issuer_tb;
    localparam int AW = 16;
    localparam int DEPTH = 4;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_valid = 0, pkt_rd = 0, pkt_wr = 0, pkt_flush = 0, pkt_ifetch = 0;
    logic pkt_llsc = 0, pkt_locked = 0, pkt_stchk = 0;
    logic [AW-1:0] pkt_addr = '0;
    logic [1:0] trk_status = 2'd0;
    logic cfg_we = 0, cfg_sel = 0;
    logic [LW-1:0] cfg_lat = '0;
    logic trk_req_valid, rsp_valid, err_pulse, ctl_valid;
    logic [3:0] trk_type, ctl_type;
    logic [1:0] rsp_code;
    logic [AW-1:0] trk_addr, ctl_addr;

    always #10 clk = ~clk;

    mreq_issuer #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_rd(pkt_rd), .pkt_wr(pkt_wr),
        .pkt_flush(pkt_flush), .pkt_ifetch(pkt_ifetch), .pkt_llsc(pkt_llsc),
        .pkt_locked(pkt_locked), .pkt_stchk(pkt_stchk), .pkt_addr(pkt_addr),
        .trk_req_valid(trk_req_valid), .trk_type(trk_type), .trk_addr(trk_addr),
        .trk_status(trk_status), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .err_pulse(err_pulse), .ctl_valid(ctl_valid), .ctl_type(ctl_type),
        .ctl_addr(ctl_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lat(cfg_lat)
    );

    typedef struct {
        logic [3:0]    t;
        logic [AW-1:0] a;
        int            rem;
    } ent_t;

    ent_t  mq[$];
    int    m_ilat = 2, m_dlat = 3;
    logic  e_rv = 0, e_err = 0;
    logic [1:0] e_code = 0;
    string e_tag = "R12";
    string cur_tag = "R12";
    int    n_tests = 0, n_fail = 0;
    bit    finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Decode expected from the requirement text (R2..R6).
    function automatic void ref_class(output bit legal, output logic [3:0] p, output logic [3:0] s);
        legal = 1; p = 0; s = 0;
        if (pkt_llsc) begin
            s = 8;
            if (pkt_wr) p = 7; else if (pkt_rd) p = 6; else legal = 0;
        end else if (pkt_locked) begin
            s = 1;
            if (pkt_wr) p = 5; else if (pkt_rd) p = 4; else legal = 0;
        end else if (pkt_rd) begin
            if (pkt_ifetch) begin p = 2; s = 2; end
            else if (pkt_stchk) begin p = 3; s = 1; end
        end else if (pkt_wr) begin p = 1; s = 1; end
        else if (pkt_flush) begin p = 9; s = 9; end
        else legal = 0;
    endfunction

    task automatic step();
        bit legal, full, ev, cv;
        logic [3:0] p, s;
        #1;
        ref_class(legal, p, s);
        full = (mq.size() >= DEPTH);
        ev = pkt_valid && legal && !full;
        chk({cur_tag, " trk_req_valid"}, trk_req_valid, ev);
        if (ev) begin
            chk({cur_tag, " trk_type"}, trk_type, p);
            chk({cur_tag, " trk_addr"}, trk_addr, pkt_addr);
        end
        cv = (mq.size() > 0) && (mq[0].rem == 0);
        chk("R8 ctl_valid", ctl_valid, cv);
        if (cv) begin
            chk("R9 ctl_type", ctl_type, mq[0].t);
            chk("R9 ctl_addr", ctl_addr, mq[0].a);
        end
        chk("R12 rsp_valid", rsp_valid, e_rv);
        if (e_rv) chk({e_tag, " rsp_code"}, rsp_code, e_code);
        chk("R6 err_pulse", err_pulse, e_err);
        // model update for the coming edge
        if (cv) void'(mq.pop_front());
        foreach (mq[i]) if (mq[i].rem > 0) mq[i].rem--;
        if (ev && trk_status == 2'd0)
            mq.push_back('{t: s, a: pkt_addr, rem: (s == 4'd2) ? m_ilat : m_dlat});
        e_rv  = pkt_valid;
        e_err = pkt_valid && !legal;
        e_code = !legal ? 2'd3 : full ? 2'd2 : (trk_status == 0) ? 2'd0 :
                 (trk_status == 1) ? 2'd1 : 2'd2;
        e_tag = cur_tag;
        if (cfg_we && cfg_lat != 0) begin
            if (cfg_sel) m_ilat = cfg_lat; else m_dlat = cfg_lat;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        pkt_valid = 0; pkt_rd = 0; pkt_wr = 0; pkt_flush = 0; pkt_ifetch = 0;
        pkt_llsc = 0; pkt_locked = 0; pkt_stchk = 0; trk_status = 0;
        cfg_we = 0; cur_tag = "R12";
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            clear_in();
            step();
        end
    endtask

    // attribute order: rd wr flush ifetch llsc locked stchk
    task automatic pkt(string tag, logic [6:0] at, logic [AW-1:0] a, logic [1:0] st);
        clear_in();
        pkt_valid = 1;
        {pkt_rd, pkt_wr, pkt_flush, pkt_ifetch, pkt_llsc, pkt_locked, pkt_stchk} = at;
        pkt_addr = a; trk_status = st; cur_tag = tag;
        step();
    endtask

    task automatic cfg(logic sel, logic [LW-1:0] v);
        clear_in();
        cfg_we = 1; cfg_sel = sel; cfg_lat = v; cur_tag = "R10";
        step();
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 trk_req_valid", trk_req_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 err_pulse", err_pulse, 0);
        chk("R1 ctl_valid", ctl_valid, 0);
        @(negedge clk);
        idle(2);
        // R1 default data latency 3 observed through R8
        pkt("R1", 7'b1000000, 16'h0100, 0);
        idle(5);
        pkt("R4", 7'b1001000, 16'h0104, 0);   // fetch, default inst latency 2
        pkt("R4", 7'b1000001, 16'h0108, 0);   // store-check read
        pkt("R4", 7'b1000000, 16'h010c, 0);
        idle(6);
        pkt("R5", 7'b0100000, 16'h0200, 0);
        pkt("R5", 7'b0010000, 16'h0204, 0);
        pkt("R5", 7'b1110000, 16'h0208, 0);   // read wins
        idle(6);
        pkt("R2", 7'b0100100, 16'h0300, 0);
        pkt("R2", 7'b1000100, 16'h0304, 0);
        pkt("R2", 7'b1100100, 16'h0308, 0);
        idle(6);
        pkt("R3", 7'b0100010, 16'h0400, 0);
        pkt("R3", 7'b1000010, 16'h0404, 0);
        pkt("R2", 7'b1000110, 16'h0408, 0);   // linked beats locked
        idle(6);
        pkt("R6", 7'b0001001, 16'h0500, 0);
        pkt("R6", 7'b0010100, 16'h0504, 0);
        pkt("R6", 7'b0010010, 16'h0508, 0);
        idle(4);
        pkt("R7", 7'b1000000, 16'h0600, 1);
        pkt("R7", 7'b0100000, 16'h0604, 2);
        pkt("R7", 7'b0010000, 16'h0608, 3);
        idle(4);
        // R9: data (3) then fetch (2) back to back, fetch must wait
        pkt("R9", 7'b1000000, 16'h0700, 0);
        pkt("R9", 7'b1001000, 16'h0704, 0);
        idle(6);
        // R10: raise data latency, zero write ignored
        cfg(0, 4'd8);
        cfg(0, 4'd0);
        cfg(1, 4'd0);
        // R11: four accepted, fifth refused as full
        pkt("R11", 7'b1000000, 16'h0800, 0);
        pkt("R11", 7'b0100000, 16'h0804, 0);
        pkt("R11", 7'b1000000, 16'h0808, 0);
        pkt("R11", 7'b0010000, 16'h080c, 0);
        pkt("R11", 7'b1000000, 16'h0810, 0);
        idle(12);
        cfg(1, 4'd1);
        pkt("R10", 7'b1001000, 16'h0900, 0);
        pkt("R10", 7'b1000000, 16'h0904, 0);
        idle(12);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule